// File: doc/BRIEF.md
# I2C Master FIFO Event and Interrupt Controller

This block sits between the host register interface of an I2C master and its bus engine. It holds a transmit byte FIFO that the host fills and the engine drains, and a receive byte FIFO that the engine fills and the host drains. It watches both FIFO levels against programmable thresholds and against a count of bytes still left in the current transfer. From these it raises "ready" events, which mean a threshold-sized batch can be moved, and "draining" events, which mean the tail of a transfer is too short ever to reach the threshold.

The bus engine also reports transfer completion, a missing acknowledge and lost arbitration as single-cycle pulses. All seven events land in a sticky status register that the host clears by writing ones. A pair of set and clear registers holds the per-event enables, and the enabled events are ORed into one interrupt line. The host reaches everything through a small 16-bit register port with two byte lanes, so both 8-bit and 16-bit accesses are supported.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After synchronous reset, the status, the enables, both FIFO levels, the remaining count and both threshold fields are zero, and `irq` is low.
- R2: Bytes written to the data register (address 5, low lane) reach `eng_tx_data` in order. A write to a full TX FIFO is dropped, and `eng_tx_pop` on an empty FIFO changes nothing.
- R3: Bytes pushed by the engine are read back in order from the data register, and each read pops one byte. A read of an empty RX FIFO returns 0. A push into a full FIFO is dropped, and `eng_rx_room` is low while the FIFO is full.
- R4: The buffer register (address 3) holds TX threshold−1 in bits [5:0], RX threshold−1 in bits [13:8] and read mode in bit 15. Writing 1 to bit 6 empties the TX FIFO and writing 1 to bit 14 empties the RX FIFO. Both of these bits read as 0.
- R5: In write mode, with pending = remaining count − TX level (floored at 0), status bit 0 (TX ready) is set when TX level < threshold and pending ≥ threshold.
- R6: In write mode, status bit 1 (TX draining) is set when TX level < threshold and 0 < pending < threshold.
- R7: In read mode, status bit 2 (RX ready) is set when RX level ≥ RX threshold.
- R8: In read mode, status bit 3 (RX draining) is set when the remaining count is 0 and 0 < RX level < RX threshold.
- R9: The pulses `eng_done`, `eng_nack` and `eng_al` set status bits 4, 5 and 6 respectively, at the same edge.
- R10: Writing ones to the status register (address 0) clears those bits, and 0xFFFF clears all of them. A set condition present at that edge wins over the clear.
- R11: Writing ones to address 1 sets enables and writing ones to address 2 clears them; both addresses read back the enables. `irq` is the OR of the enabled status bits and follows them in the same cycle.
- R12: A write to the count register (address 4) loads the remaining count, except that a resulting value of zero is ignored. The count drops by one for each accepted engine pop in write mode or accepted engine push in read mode, and it stops at 0.
- R13: `reg_be[0]` selects bits [7:0] and `reg_be[1]` selects bits [15:8], and a write with no lane enabled has no effect. The status-of-buffers register (address 6) reads the depth code in [15:14] (depth = 8 << code), the RX level in [13:8] and the TX level in [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on the data address) |
| reg_addr | input | 3 | Register address |
| reg_be | input | 2 | Byte-lane enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| eng_tx_pop | input | 1 | Engine takes the head TX byte |
| eng_tx_data | output | 8 | Head TX byte |
| eng_tx_avail | output | 1 | TX FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_room | output | 1 | RX FIFO not full |
| eng_done | input | 1 | Transfer finished pulse |
| eng_nack | input | 1 | No-acknowledge pulse |
| eng_al | input | 1 | Arbitration-lost pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The pulse-driven status bits (R9), register writes and FIFO moves take effect at the edge where they are sampled. The threshold and draining bits (R5–R8) are evaluated on the registered levels and count, so they appear one edge after the state change that causes them. `irq` and `reg_rdata` are combinational from registered state, so they settle within the same cycle. The bench drives on the falling edge, advances a queue-based model at each rising edge, and compares all outputs 1 ns after the falling edge. Its directed reads wait the extra edge that the threshold bits need before they check a literal.

// File: rtl/fifo_evt_pkg.sv
package fifo_evt_pkg;

    localparam int DW  = 16;
    localparam int NEV = 7;

    typedef enum logic [2:0] {
        A_STAT    = 3'd0,
        A_IEN_SET = 3'd1,
        A_IEN_CLR = 3'd2,
        A_BUF     = 3'd3,
        A_CNT     = 3'd4,
        A_DATA    = 3'd5,
        A_BSTAT   = 3'd6,
        A_NONE    = 3'd7
    } reg_addr_e;

    localparam int EV_XRDY = 0;
    localparam int EV_XDR  = 1;
    localparam int EV_RRDY = 2;
    localparam int EV_RDR  = 3;
    localparam int EV_ARDY = 4;
    localparam int EV_NACK = 5;
    localparam int EV_AL   = 6;

    localparam int BUF_TX_FLUSH = 6;
    localparam int BUF_RX_FLUSH = 14;
    localparam int BUF_RD_MODE  = 15;

    typedef logic [NEV-1:0] ev_vec_t;

    typedef struct packed {
        logic       rd_mode;
        logic [5:0] rx_thr_m1;
        logic [5:0] tx_thr_m1;
    } buf_cfg_t;

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [1:0]    be);
        logic [DW-1:0] m;
        m = lane_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter  int DEPTH = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int LW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level,
    output logic          empty
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (level == '0);
    assign push_ok = push && (level != LW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/evt_detect.sv
module evt_detect
    import fifo_evt_pkg::*;
#(
    parameter int LW = 5
) (
    input  buf_cfg_t      cfg,
    input  logic [LW-1:0] tx_lvl,
    input  logic [LW-1:0] rx_lvl,
    input  logic [15:0]   rem,
    input  logic          done_p,
    input  logic          nack_p,
    input  logic          al_p,
    output ev_vec_t       set
);
    logic [15:0] tx_thr;
    logic [15:0] rx_thr;
    logic [15:0] tx16;
    logic [15:0] rx16;
    logic [15:0] pending;
    logic        tx_low;

    always_comb begin
        tx_thr  = 16'(cfg.tx_thr_m1) + 16'd1;
        rx_thr  = 16'(cfg.rx_thr_m1) + 16'd1;
        tx16    = 16'(tx_lvl);
        rx16    = 16'(rx_lvl);
        pending = (rem > tx16) ? (rem - tx16) : 16'd0;
        tx_low  = (tx16 < tx_thr);

        set          = '0;
        set[EV_XRDY] = !cfg.rd_mode && tx_low && (pending >= tx_thr);
        set[EV_XDR]  = !cfg.rd_mode && tx_low && (pending != 16'd0) && (pending < tx_thr);
        set[EV_RRDY] = cfg.rd_mode && (rx16 >= rx_thr);
        set[EV_RDR]  = cfg.rd_mode && (rem == 16'd0) && (rx16 != 16'd0) && (rx16 < rx_thr);
        set[EV_ARDY] = done_p;
        set[EV_NACK] = nack_p;
        set[EV_AL]   = al_p;
    end
endmodule

// File: rtl/evt_status.sv
module evt_status
    import fifo_evt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set,
    input  ev_vec_t w1c,
    input  ev_vec_t en_set,
    input  ev_vec_t en_clr,
    output ev_vec_t stat,
    output ev_vec_t ien,
    output logic    irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            ien  <= '0;
        end else begin
            stat <= (stat & ~w1c) | set;
            ien  <= (ien & ~en_clr) | en_set;
        end
    end

    assign irq = |(stat & ien);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH_CODE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_avail,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        eng_rx_room,
    input  logic        eng_done,
    input  logic        eng_nack,
    input  logic        eng_al,
    output logic        irq
);
    // Depth code is limited to 0..2 so both levels fit the 6-bit read fields.
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int LW    = $clog2(DEPTH) + 1;

    reg_addr_e     addr;
    logic [15:0]   wmask;
    logic          wr_any;
    logic          stat_wr, ien_set_wr, ien_clr_wr, buf_wr, cnt_wr, data_wr;
    logic          tx_flush, rx_flush;
    logic          rx_pop;
    logic          tx_pop_ok, rx_push_ok;
    buf_cfg_t      cfg_q;
    logic [15:0]   rem_q;
    logic [15:0]   cnt_new;
    logic [7:0]    tx_head, rx_head;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_empty, rx_empty;
    ev_vec_t       ev_set, w1c, en_set, en_clr, stat, ien;

    assign addr       = reg_addr_e'(reg_addr);
    assign wmask      = lane_mask(reg_be);
    assign wr_any     = reg_wr && (reg_be != 2'b00);
    assign stat_wr    = wr_any && (addr == A_STAT);
    assign ien_set_wr = wr_any && (addr == A_IEN_SET);
    assign ien_clr_wr = wr_any && (addr == A_IEN_CLR);
    assign buf_wr     = wr_any && (addr == A_BUF);
    assign cnt_wr     = wr_any && (addr == A_CNT);
    assign data_wr    = wr_any && (addr == A_DATA) && reg_be[0];
    assign rx_pop     = reg_rd && (addr == A_DATA) && reg_be[0];

    assign tx_flush = buf_wr && reg_be[0] && reg_wdata[BUF_TX_FLUSH];
    assign rx_flush = buf_wr && reg_be[1] && reg_wdata[BUF_RX_FLUSH];

    assign w1c    = stat_wr    ? (reg_wdata[NEV-1:0] & wmask[NEV-1:0]) : '0;
    assign en_set = ien_set_wr ? (reg_wdata[NEV-1:0] & wmask[NEV-1:0]) : '0;
    assign en_clr = ien_clr_wr ? (reg_wdata[NEV-1:0] & wmask[NEV-1:0]) : '0;

    // Buffer configuration, each lane written independently.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (buf_wr) begin
            if (reg_be[0]) cfg_q.tx_thr_m1 <= reg_wdata[5:0];
            if (reg_be[1]) begin
                cfg_q.rx_thr_m1 <= reg_wdata[13:8];
                cfg_q.rd_mode   <= reg_wdata[BUF_RD_MODE];
            end
        end
    end

    // Remaining byte count of the current transfer.
    assign tx_pop_ok  = eng_tx_pop && !tx_empty;
    assign rx_push_ok = eng_rx_push && (rx_lvl != LW'(DEPTH));
    assign cnt_new    = lane_merge(rem_q, reg_wdata, reg_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (cnt_wr && (cnt_new != 16'd0)) begin
            rem_q <= cnt_new;
        end else if ((cfg_q.rd_mode ? rx_push_ok : tx_pop_ok) && (rem_q != 16'd0)) begin
            rem_q <= rem_q - 16'd1;
        end
    end

    byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(data_wr), .push_data(reg_wdata[7:0]),
        .pop(eng_tx_pop), .head(tx_head), .level(tx_lvl), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head(rx_head), .level(rx_lvl), .empty(rx_empty)
    );

    evt_detect #(.LW(LW)) u_det (
        .cfg(cfg_q), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .rem(rem_q),
        .done_p(eng_done), .nack_p(eng_nack), .al_p(eng_al), .set(ev_set)
    );

    evt_status u_stat (
        .clk(clk), .rst(rst), .set(ev_set), .w1c(w1c),
        .en_set(en_set), .en_clr(en_clr), .stat(stat), .ien(ien), .irq(irq)
    );

    assign eng_tx_data  = tx_head;
    assign eng_tx_avail = !tx_empty;
    assign eng_rx_room  = (rx_lvl != LW'(DEPTH));

    always_comb begin
        unique case (addr)
            A_STAT:    reg_rdata = {{(16-NEV){1'b0}}, stat};
            A_IEN_SET,
            A_IEN_CLR: reg_rdata = {{(16-NEV){1'b0}}, ien};
            A_BUF:     reg_rdata = {cfg_q.rd_mode, 1'b0, cfg_q.rx_thr_m1, 2'b00, cfg_q.tx_thr_m1};
            A_CNT:     reg_rdata = rem_q;
            A_DATA:    reg_rdata = rx_empty ? 16'h0000 : {8'h00, rx_head};
            A_BSTAT:   reg_rdata = {2'(DEPTH_CODE), 6'(rx_lvl), 2'b00, 6'(tx_lvl)};
            default:   reg_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
    import fifo_evt_pkg::*;
#(
    parameter int LW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [15:0]   rem_q,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input ev_vec_t       stat,
    input ev_vec_t       ien,
    input logic          irq,
    input logic          eng_done,
    input logic          eng_nack,
    input logic          eng_al,
    input logic          cnt_wr,
    input logic          tx_flush,
    input logic          rx_flush
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (stat == '0 && ien == '0 && !irq && tx_lvl == '0 && rx_lvl == '0 && rem_q == '0));

    a_r2_tx_bound: assert property (@(posedge clk) disable iff (rst)
        tx_lvl <= LW'(DEPTH));

    a_r3_rx_bound: assert property (@(posedge clk) disable iff (rst)
        rx_lvl <= LW'(DEPTH));

    a_r4_tx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_lvl == '0));

    a_r4_rx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_lvl == '0));

    a_r9_done_sets: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> stat[EV_ARDY]);

    a_r9_nack_sets: assert property (@(posedge clk) disable iff (rst)
        eng_nack |=> stat[EV_NACK]);

    a_r9_al_sets: assert property (@(posedge clk) disable iff (rst)
        eng_al |=> stat[EV_AL]);

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

    a_r12_count_never_grows: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (rem_q <= $past(rem_q)));
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.LW(LW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rem_q(rem_q), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .stat(stat), .ien(ien), .irq(irq), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_al(eng_al), .cnt_wr(cnt_wr), .tx_flush(tx_flush), .rx_flush(rx_flush)
);

// File: tb/sim_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_irq_ctrl;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [1:0]  reg_be = 2'b11;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        eng_tx_pop = 0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_avail;
    logic        eng_rx_push = 0;
    logic [7:0]  eng_rx_data = 0;
    logic        eng_rx_room;
    logic        eng_done = 0, eng_nack = 0, eng_al = 0;
    logic        irq;

    always #2.5 clk = ~clk;

    fifo_irq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_room(eng_rx_room),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_al(eng_al), .irq(irq)
    );

    // Behavioural reference state
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [15:0] m_rem;
    logic        m_rd;
    logic [5:0]  m_txm1, m_rxm1;
    logic [6:0]  m_stat, m_ien;
    int          checks = 0;
    int          errors = 0;

    function automatic logic [15:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0:    return {9'd0, m_stat};
            3'd1,
            3'd2:    return {9'd0, m_ien};
            3'd3:    return {m_rd, 1'b0, m_rxm1, 2'b00, m_txm1};
            3'd4:    return m_rem;
            3'd5:    return (rxq.size() > 0) ? {8'h00, rxq[0]} : 16'h0000;
            3'd6:    return {2'b01, 6'(rxq.size()), 2'b00, 6'(txq.size())};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0:    return "R10";
            3'd1,
            3'd2:    return "R11";
            3'd3:    return "R4";
            3'd4:    return "R12";
            3'd5:    return "R3";
            default: return "R13";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            m_rem = 0; m_rd = 0; m_txm1 = 0; m_rxm1 = 0; m_stat = 0; m_ien = 0;
        end else begin
            int tl, rl, thrt, thrr, pend;
            logic [6:0] set, w1c, ens, enc;
            logic [15:0] m, newc;
            logic wr, txpop, txpush, rxpush, rxpop, txfl, rxfl, dec;
            tl = txq.size(); rl = rxq.size();
            thrt = int'(m_txm1) + 1; thrr = int'(m_rxm1) + 1;
            pend = (int'(m_rem) > tl) ? int'(m_rem) - tl : 0;
            set = 0;
            set[0] = !m_rd && tl < thrt && pend >= thrt;
            set[1] = !m_rd && tl < thrt && pend > 0 && pend < thrt;
            set[2] = m_rd && rl >= thrr;
            set[3] = m_rd && m_rem == 0 && rl > 0 && rl < thrr;
            set[4] = eng_done; set[5] = eng_nack; set[6] = eng_al;
            m   = {{8{reg_be[1]}}, {8{reg_be[0]}}};
            wr  = reg_wr && (reg_be != 0);
            w1c = (wr && reg_addr == 0) ? 7'(reg_wdata & m) : 7'd0;
            ens = (wr && reg_addr == 1) ? 7'(reg_wdata & m) : 7'd0;
            enc = (wr && reg_addr == 2) ? 7'(reg_wdata & m) : 7'd0;
            m_stat = (m_stat & ~w1c) | set;
            m_ien  = (m_ien & ~enc) | ens;
            txpop  = eng_tx_pop && tl > 0;
            txpush = wr && reg_addr == 5 && reg_be[0] && tl < DEPTH;
            rxpush = eng_rx_push && rl < DEPTH;
            rxpop  = reg_rd && reg_addr == 5 && reg_be[0] && rl > 0;
            txfl   = wr && reg_addr == 3 && reg_be[0] && reg_wdata[6];
            rxfl   = wr && reg_addr == 3 && reg_be[1] && reg_wdata[14];
            if (txfl) txq.delete();
            else begin
                if (txpop)  void'(txq.pop_front());
                if (txpush) txq.push_back(reg_wdata[7:0]);
            end
            if (rxfl) rxq.delete();
            else begin
                if (rxpop)  void'(rxq.pop_front());
                if (rxpush) rxq.push_back(eng_rx_data);
            end
            dec  = m_rd ? rxpush : txpop;
            newc = (m_rem & ~m) | (reg_wdata & m);
            if (wr && reg_addr == 4 && newc != 0) m_rem = newc;
            else if (dec && m_rem != 0) m_rem = m_rem - 1;
            if (wr && reg_addr == 3) begin
                if (reg_be[0]) m_txm1 = reg_wdata[5:0];
                if (reg_be[1]) begin m_rxm1 = reg_wdata[13:8]; m_rd = reg_wdata[15]; end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        if (!rst) begin
            chk(tag_of(reg_addr), reg_rdata, exp_rdata(reg_addr));
            chk("R11", {15'd0, irq}, {15'd0, |(m_stat & m_ien)});
            chk("R3", {15'd0, eng_rx_room}, {15'd0, rxq.size() < DEPTH});
            chk("R2", {15'd0, eng_tx_avail}, {15'd0, txq.size() > 0});
            if (txq.size() > 0) chk("R2", {8'd0, eng_tx_data}, {8'd0, txq[0]});
        end
    endtask

    task automatic cyc();
        #1;
        compare_all();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_be = 2'b11;
        eng_tx_pop = 0; eng_rx_push = 0; eng_done = 0; eng_nack = 0; eng_al = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1;
        cyc();
    endtask

    task automatic peek(input logic [2:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
        cyc();
    endtask

    task automatic host_read(input logic [15:0] exp, input string req);
        reg_addr = 3'd5; reg_rd = 1;
        #1 chk(req, reg_rdata, exp);
        cyc();
    endtask

    task automatic tx_take(input logic [7:0] exp);
        eng_tx_pop = 1;
        #1 chk("R2", {8'd0, eng_tx_data}, {8'd0, exp});
        cyc();
    endtask

    task automatic rx_give(input logic [7:0] d);
        eng_rx_push = 1; eng_rx_data = d;
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        peek(3'd0, 16'h0000, "R1");
        peek(3'd3, 16'h0000, "R1");
        peek(3'd4, 16'h0000, "R1");
        #1 chk("R1", {15'd0, irq}, 16'd0);
        peek(3'd6, 16'h4000, "R13");

        // R5 TX ready
        wr(3'd1, 16'h007F);
        wr(3'd3, 16'h0003);
        wr(3'd4, 16'd10);
        idle(2);
        peek(3'd0, 16'h0001, "R5");
        #1 chk("R11", {15'd0, irq}, 16'd1);
        wr(3'd5, 16'h00AA); wr(3'd5, 16'h00BB); wr(3'd5, 16'h00CC); wr(3'd5, 16'h00DD);
        wr(3'd0, 16'h0001);
        peek(3'd0, 16'h0000, "R10");
        tx_take(8'hAA); tx_take(8'hBB);
        idle(2);
        wr(3'd0, 16'h007F);
        peek(3'd0, 16'h0001, "R10");
        wr(3'd5, 16'h00EE); wr(3'd5, 16'h00FF);
        tx_take(8'hCC); tx_take(8'hDD); tx_take(8'hEE); tx_take(8'hFF);
        // R6 TX draining: remaining 4, level 2 after two writes
        wr(3'd5, 16'h0011); wr(3'd5, 16'h0022);
        wr(3'd0, 16'h007F);
        peek(3'd0, 16'h0002, "R6");

        // R4 flush and read-as-zero bits
        wr(3'd3, 16'h0043);
        peek(3'd6, 16'h4000, "R4");
        peek(3'd3, 16'h0003, "R4");
        eng_tx_pop = 1; cyc();
        peek(3'd4, 16'h0004, "R12");

        // R13 byte lanes and R12 zero load
        wr(3'd4, 16'h0300, 2'b10);
        peek(3'd4, 16'h0304, "R13");
        wr(3'd4, 16'hFFFF, 2'b00);
        peek(3'd4, 16'h0304, "R13");
        wr(3'd4, 16'h0000);
        peek(3'd4, 16'h0304, "R12");

        // R2 overflow and order
        for (int i = 0; i < 17; i++) wr(3'd5, 16'(8'h40 + i));
        peek(3'd6, 16'h4010, "R2");
        for (int i = 0; i < 16; i++) tx_take(8'(8'h40 + i));
        #1 chk("R2", {15'd0, eng_tx_avail}, 16'd0);
        peek(3'd4, 16'h02F4, "R12");

        // R9 engine pulses in read mode
        wr(3'd3, 16'h8203);
        wr(3'd4, 16'd5);
        wr(3'd0, 16'hFFFF);
        peek(3'd0, 16'h0000, "R10");
        eng_nack = 1; cyc();
        peek(3'd0, 16'h0020, "R9");
        eng_al = 1; cyc();
        peek(3'd0, 16'h0060, "R9");
        eng_done = 1; cyc();
        peek(3'd0, 16'h0070, "R9");
        wr(3'd2, 16'h0070);
        #1 chk("R11", {15'd0, irq}, 16'd0);
        peek(3'd1, 16'h000F, "R11");

        // R7 RX ready, R3 order
        rx_give(8'h11); rx_give(8'h22); rx_give(8'h33);
        idle(1);
        peek(3'd0, 16'h0074, "R7");
        #1 chk("R11", {15'd0, irq}, 16'd1);
        host_read(16'h0011, "R3"); host_read(16'h0022, "R3"); host_read(16'h0033, "R3");
        host_read(16'h0000, "R3");
        wr(3'd0, 16'h007F);
        peek(3'd0, 16'h0000, "R10");

        // R8 RX draining
        rx_give(8'h44); rx_give(8'h55);
        idle(1);
        peek(3'd0, 16'h0008, "R8");
        for (int i = 0; i < 15; i++) rx_give(8'(8'h60 + i));
        #1 chk("R3", {15'd0, eng_rx_room}, 16'd0);
        peek(3'd6, 16'h5000, "R3");
        peek(3'd4, 16'h0000, "R12");
        host_read(16'h0044, "R3");
        wr(3'd3, 16'hC203);
        peek(3'd6, 16'h4000, "R4");
        peek(3'd3, 16'h8203, "R4");
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule